// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

The sequencer sets the frame timing for a four-input ADC multiplexer. It runs on a fast CK clock and divides it down to a slow conversion tick: one tick period is `CK_PER_TICK` CK cycles, 150 by default. Each frame first steps through the active channel slots in a fixed order, giving each slot two or three tick periods. It then spends one tick period in a settle state, after which the next frame starts. No analog converter is modelled. The end of each conversion is taken purely from the cycle count, and a strobe with the channel index marks it so that a data-memory writer can store the result.

Two configuration inputs are captured at the start of every frame. `mux_div` sets how many slots are active; slots beyond that count are skipped. `fir_long` sets how many tick periods each conversion takes. The `en` input starts the sequence. If `en` is low at the end of a frame, the sequence stops once that frame's settle period has finished.

Top module: `adc_frame_seq`

## Requirements
- R1: During reset, and after reset until a frame starts, `mux_state` reads 4 (settle/idle) and `tick32`, `mux_sync` and `conv_done` are all 0.
- R2: While a frame sequence runs, `tick32` is a one-CK pulse. It occurs on the first CK cycle of the frame and then every `CK_PER_TICK` CK cycles.
- R3: A frame lasts (1 + D*2) tick periods when `fir_long`=0 and (1 + D*3) tick periods when `fir_long`=1. D is the effective slot count.
- R4: `mux_sync` is a one-CK pulse on the first CK cycle of each frame. That is the cycle after a clock edge that samples `en`=1 while idle, or the cycle after the last CK cycle of a settle period when `en` is still 1.
- R5: `mux_state` encodes slots 0..3 as 0..3 and the settle state as 4. A frame visits slots 0, 1, …, D-1 in order, each for a whole number of tick periods (2 or 3), then state 4 for exactly one tick period.
- R6: `conv_done` is a one-CK pulse on the first CK cycle after each slot ends. `conv_chan` carries the index of that slot. There are exactly D pulses per frame and none on the first cycle of a frame.
- R7: `mux_div`=0 is taken as D=1, values 1..4 are used as given, and values above 4 are taken as D=4.
- R8: `mux_div` and `fir_long` are sampled only at the clock edge that starts a frame. A change made at any later cycle, including the frame's first cycle, has no effect until the next frame.
- R9: If `en` is 0 at the end of a settle period, the sequencer goes idle with `mux_state`=4 and no ticks. A later `en`=1 starts a new frame at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast CK clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run request, checked at idle and at each frame end |
| mux_div | input | 3 | Requested number of active slots |
| fir_long | input | 1 | 0: 2 tick periods per conversion, 1: 3 |
| tick32 | output | 1 | One-CK pulse at each slow tick period start |
| mux_sync | output | 1 | One-CK pulse at frame start |
| mux_state | output | 3 | Current slot 0..3, or 4 for settle/idle |
| conv_done | output | 1 | One-CK conversion-complete strobe |
| conv_chan | output | 2 | Slot index of the completed conversion |

## Verification
Two things can fall in the same cycle: the frame boundary that latches the configuration, and a change of that configuration by the user. The bench changes `mux_div` on the last CK cycle of a settle period and expects the new value to set the length of the frame that follows. It then changes the configuration on the first cycle of a frame, after the latching edge, and expects that frame to keep the old length and slot count. Both outcomes are judged by checking, cycle by cycle, the state, tick, strobe and sync positions against values computed from the frame formula.

// File: rtl/adc_fs_pkg.sv
package adc_fs_pkg;

  typedef enum logic {
    FIR_SHORT = 1'b0,
    FIR_LONG  = 1'b1
  } fir_sel_e;

  // Map a requested slot count onto the legal range 1..nslots.
  function automatic int clamp_div(input int raw, input int nslots);
    if (raw == 0)           return 1;
    else if (raw > nslots)  return nslots;
    else                    return raw;
  endfunction

endpackage

// File: rtl/adc_fs_prescaler.sv
module adc_fs_prescaler #(
  parameter int CK_PER_TICK = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pre_last,
  output logic tick_start
);
  localparam int PW = (CK_PER_TICK > 1) ? $clog2(CK_PER_TICK) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(CK_PER_TICK - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (!run)          pre_d = '0;
    else if (pre_last) pre_d = '0;
    else               pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign pre_last   = run && (pre_q == PRE_MAX);
  assign tick_start = run && (pre_q == '0);

  a_r2_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_MAX);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_q == PRE_MAX) |=> (pre_q == '0));

endmodule

// File: rtl/adc_fs_cfg.sv
module adc_fs_cfg #(
  parameter int NUM_SLOTS = 4,
  parameter int TPC_SHORT = 2,
  parameter int TPC_LONG  = 3,
  localparam int SW = $clog2(NUM_SLOTS + 1),
  localparam int TW = $clog2(TPC_LONG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] div_raw,
  input  logic          fir_raw,
  output logic [SW-1:0] div_q,
  output logic [TW-1:0] tpc_q
);
  import adc_fs_pkg::*;

  logic [SW-1:0] div_eff;
  logic [TW-1:0] tpc_eff;
  fir_sel_e      fir_sel;

  always_comb begin
    fir_sel = fir_sel_e'(fir_raw);
    div_eff = SW'(clamp_div(int'(div_raw), NUM_SLOTS));
    tpc_eff = (fir_sel == FIR_LONG) ? TW'(TPC_LONG) : TW'(TPC_SHORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= SW'(1);
      tpc_q <= TW'(TPC_SHORT);
    end else if (load) begin
      div_q <= div_eff;
      tpc_q <= tpc_eff;
    end
  end

  a_r7_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) && (div_q <= SW'(NUM_SLOTS)));

endmodule

// File: rtl/adc_fs_slot_ctrl.sv
module adc_fs_slot_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int TPC_LONG  = 3,
  localparam int SW = $clog2(NUM_SLOTS + 1),
  localparam int TW = $clog2(TPC_LONG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pre_last,
  input  logic [SW-1:0] div_q,
  input  logic [TW-1:0] tpc_q,
  output logic          run_q,
  output logic [SW-1:0] slot_q,
  output logic [TW-1:0] tk_q,
  output logic          load,
  output logic          adv
);
  localparam logic [SW-1:0] SETTLE = SW'(NUM_SLOTS);

  logic          run_d;
  logic [SW-1:0] slot_d;
  logic [TW-1:0] tk_d;
  logic          start, boundary, in_slot;

  always_comb begin
    start    = !run_q && en;
    boundary = run_q && pre_last && (slot_q == SETTLE);
    in_slot  = run_q && pre_last && (slot_q != SETTLE);
    load     = start || (boundary && en);
    adv      = in_slot && (tk_q == tpc_q - 1'b1);

    run_d  = run_q;
    slot_d = slot_q;
    tk_d   = tk_q;
    if (load) begin
      run_d  = 1'b1;
      slot_d = '0;
      tk_d   = '0;
    end else if (boundary) begin
      run_d  = 1'b0;
      slot_d = SETTLE;
      tk_d   = '0;
    end else if (adv) begin
      tk_d   = '0;
      slot_d = (slot_q == div_q - 1'b1) ? SETTLE : slot_q + 1'b1;
    end else if (in_slot) begin
      tk_d   = tk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= SETTLE;
      tk_q   <= '0;
    end else begin
      run_q  <= run_d;
      slot_q <= slot_d;
      tk_q   <= tk_d;
    end
  end

  a_r5_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SETTLE);
  a_r5_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(slot_q) && slot_q != '0 && slot_q != SETTLE)
      |-> (slot_q == $past(slot_q) + 1'b1));
  a_r9_idle_settle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (slot_q == SETTLE));

endmodule

// File: rtl/adc_fs_event.sv
module adc_fs_event #(
  parameter int NUM_SLOTS = 4,
  localparam int SW = $clog2(NUM_SLOTS + 1),
  localparam int CW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [SW-1:0] slot_q,
  output logic          done_q,
  output logic [CW-1:0] chan_q
);
  logic          done_d;
  logic [CW-1:0] chan_d;

  always_comb begin
    done_d = adv;
    chan_d = adv ? slot_q[CW-1:0] : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      chan_q <= '0;
    end else begin
      done_q <= done_d;
      chan_q <= chan_d;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int CK_PER_TICK = 150,
  parameter int NUM_SLOTS   = 4,
  parameter int TPC_SHORT   = 2,
  parameter int TPC_LONG    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SW = $clog2(NUM_SLOTS + 1),
  localparam int CW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TW = $clog2(TPC_LONG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] mux_div,
  input  logic          fir_long,
  output logic          tick32,
  output logic          mux_sync,
  output logic [SW-1:0] mux_state,
  output logic          conv_done,
  output logic [CW-1:0] conv_chan
);
  // Reset: asserts asynchronously, releases after SYNC_STAGES edges.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s = rst_pipe[SYNC_STAGES-1];

  logic          run_q, pre_last, tick_start, load, adv;
  logic [SW-1:0] slot_q, div_q;
  logic [TW-1:0] tk_q, tpc_q;

  adc_fs_prescaler #(.CK_PER_TICK(CK_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_s), .run(run_q),
    .pre_last(pre_last), .tick_start(tick_start)
  );

  adc_fs_cfg #(.NUM_SLOTS(NUM_SLOTS), .TPC_SHORT(TPC_SHORT), .TPC_LONG(TPC_LONG)) u_cfg (
    .clk(clk), .rst_n(rst_s), .load(load),
    .div_raw(mux_div), .fir_raw(fir_long),
    .div_q(div_q), .tpc_q(tpc_q)
  );

  adc_fs_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .TPC_LONG(TPC_LONG)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .en(en), .pre_last(pre_last),
    .div_q(div_q), .tpc_q(tpc_q),
    .run_q(run_q), .slot_q(slot_q), .tk_q(tk_q),
    .load(load), .adv(adv)
  );

  adc_fs_event #(.NUM_SLOTS(NUM_SLOTS)) u_evt (
    .clk(clk), .rst_n(rst_s), .adv(adv), .slot_q(slot_q),
    .done_q(conv_done), .chan_q(conv_chan)
  );

  assign tick32    = tick_start;
  assign mux_sync  = tick_start && (slot_q == '0) && (tk_q == '0);
  assign mux_state = slot_q;

  a_r4_sync_vs_done: assert property (@(posedge clk) disable iff (!rst_s)
    !(mux_sync && conv_done));
  a_r6_done_on_tick: assert property (@(posedge clk) disable iff (!rst_s)
    conv_done |-> tick32);
  a_r6_chan_bound: assert property (@(posedge clk) disable iff (!rst_s)
    conv_done |-> (SW'(conv_chan) < div_q));
  a_r8_cfg_frame_only: assert property (@(posedge clk) disable iff (!rst_s)
    (!$stable(div_q) || !$stable(tpc_q)) |-> mux_sync);

endmodule

// File: tb/adc_frame_seq_bench.sv
module adc_frame_seq_bench;
  localparam int P  = 150;
  localparam int NV = 8;
  // columns: mux_div, fir_long, expected effective slots, expected frame ticks
  localparam int VEC [NV][4] = '{
    '{1, 0, 1, 3}, '{2, 1, 2, 7}, '{4, 0, 4, 9}, '{4, 1, 4, 13},
    '{3, 0, 3, 7}, '{0, 1, 1, 4}, '{7, 0, 4, 9}, '{2, 0, 2, 5}
  };

  logic       clk = 1'b0;
  logic       rst_n, en, fir_long;
  logic [2:0] mux_div;
  logic       tick32, mux_sync, conv_done;
  logic [2:0] mux_state;
  logic [1:0] conv_chan;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  adc_frame_seq #(.CK_PER_TICK(P)) u_adc_frame_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .mux_div(mux_div), .fir_long(fir_long),
    .tick32(tick32), .mux_sync(mux_sync), .mux_state(mux_state),
    .conv_done(conv_done), .conv_chan(conv_chan)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(mux_state == 3'd4, {tag, " state"}, mux_state, 4);
    chk(!tick32,    {tag, " tick"}, tick32, 0);
    chk(!mux_sync,  {tag, " sync"}, mux_sync, 0);
    chk(!conv_done, {tag, " done"}, conv_done, 0);
  endtask

  task automatic chk_pos(input int c, input int eff, input int tpc, input string tag);
    int tk, exp_st, cv;
    bit exp_done;
    tk     = c / P;
    exp_st = (tk / tpc < eff) ? tk / tpc : 4;
    cv     = c / (tpc * P);
    exp_done = (c > 0) && (c % (tpc * P) == 0) && (cv <= eff);
    chk(int'(mux_state) == exp_st, {tag, " R5 state"}, mux_state, exp_st);
    chk(tick32 == (c % P == 0), {tag, " R2 tick"}, tick32, int'(c % P == 0));
    chk(mux_sync == (c == 0), {tag, " R4 sync"}, mux_sync, int'(c == 0));
    chk(conv_done == exp_done, {tag, " R6 done"}, conv_done, exp_done);
    if (exp_done) chk(int'(conv_chan) == cv - 1, {tag, " R6 chan"}, conv_chan, cv - 1);
  endtask

  // Called at the negedge of a frame's first cycle; returns at the next frame's first cycle.
  task automatic run_frame(input int eff, input int tpc, input int ticks, input int chg_at,
                           input int nd, input int nf, input bit stop, input string tag);
    int len;
    len = ticks * P;
    chk_pos(0, eff, tpc, tag);
    for (int c = 1; c <= len; c++) begin
      if (c - 1 == chg_at) begin
        mux_div = 3'(nd); fir_long = nf[0];
        if (stop) en = 1'b0;
      end
      @(negedge clk);
      if (c < len) chk_pos(c, eff, tpc, tag);
    end
    if (stop) chk_idle({tag, " R9 stop"});
    else chk(mux_sync == 1'b1, {tag, " R3 frame length"}, mux_sync, 1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int nx;
    rst_n = 1'b0; en = 1'b0; mux_div = 3'd1; fir_long = 1'b0;
    repeat (4) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_idle("R1 after reset");

    // Table walk: each frame's successor config is applied mid-frame (R8, R7 rows).
    mux_div = 3'(VEC[0][0]); fir_long = VEC[0][1][0]; en = 1'b1;
    @(negedge clk);
    chk(mux_sync == 1'b1, "R4 start latency", mux_sync, 1);
    for (int i = 0; i < NV; i++) begin
      nx = (i + 1 < NV) ? i + 1 : 0;
      run_frame(VEC[i][2], VEC[i][1] ? 3 : 2, VEC[i][3], P / 2,
                VEC[nx][0], VEC[nx][1], 1'b0, (VEC[i][0] != VEC[i][2]) ? "R7 vec" : "R3 vec");
    end

    // R8: change on the last cycle of settle is taken by the next frame.
    run_frame(1, 2, 3, 3 * P - 1, 2, 0, 1'b0, "R8 boundary");
    // R8: change on the first cycle of a frame is not taken by it.
    run_frame(2, 2, 5, 0, 4, 1, 1'b0, "R8 late");
    // R9: drop en mid-frame; the frame completes, then idle.
    run_frame(4, 3, 13, 2 * P, 4, 1, 1'b1, "R9 stop");
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      if (k % 50 == 0) chk_idle("R9 idle hold");
    end

    // R9/R4: restart from idle.
    mux_div = 3'd1; fir_long = 1'b0; en = 1'b1;
    @(negedge clk);
    chk(mux_sync == 1'b1, "R9 restart sync", mux_sync, 1);
    chk(mux_state == 3'd0, "R9 restart state", mux_state, 0);

    // R1: asynchronous reset mid-frame.
    repeat (200) @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    #1;
    chk_idle("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_idle("R1 post reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule